// File: doc/BRIEF.md
# Wait-for-Interrupt Ready Controller

This block owns one bidirectional, active-high ready line shared by a processor core and the rest of the system. Any agent may pull the line low through an open-drain driver to freeze the core in its current state. The block also pulls the line low on its own after the core reports that it has executed a wait instruction. The line then stays parked low until an abort, a non-maskable interrupt or a maskable interrupt request wakes it, or until the block's reset clears it.

The resolved pad level comes back into the block and is synchronised. The halt output follows that level, so a low level halts the core whether the block drove it or another agent did. A halt is applied and removed only on a falling clock edge. When the wake source calls for vectoring, the block emits a one-cycle take-vector pulse. If the only wake source is an interrupt request while the core's interrupt disable flag is set, the block emits a resume-without-vector pulse instead, and the core simply continues with the next instruction. If another agent holds the line high, the wait cannot take effect. The block detects this and withdraws its drive. The stop instruction strobe has no influence on the line.

Top module: `wrc_ready_ctrl`

## Requirements
- R1: A low resolved pad level asserts `core_halt` at the first falling clock edge after SYNC_STAGES rising edges have sampled it.
- R2: After the pad level returns high, `core_halt` falls at the first falling clock edge after SYNC_STAGES rising edges. It never changes between a rising edge and the following falling edge.
- R3: A `wai_exec` pulse sampled while the block is not driving sets `rdy_drive_low` high from the next rising edge onward.
- R4: While `rdy_drive_low` is high, a low level on `abort_n`, `nmi_n` or `irq_n` at a rising edge clears `rdy_drive_low` after that edge.
- R5: A wake caused by `abort_n` or `nmi_n` low, or by `irq_n` low with `irq_mask` = 0, produces `take_vector` high for exactly the one cycle after the wake edge. `take_vector` and `resume_no_vector` are never high together.
- R6: A wake in which only `irq_n` is low and `irq_mask` = 1 produces `resume_no_vector` high for one cycle and no `take_vector`.
- R7: If the synchronised pad level is still high SYNC_STAGES+1 cycles after the drive began, the drive is withdrawn at the next rising edge and neither pulse is produced.
- R8: `stp_exec` never changes `rdy_drive_low`.
- R9: `rdy_pullup_en` is always the inverse of `rdy_drive_low`.
- R10: While `rst_n` is low, `rdy_drive_low` is 0 immediately, without waiting for a clock. `rdy_pullup_en`=1, `core_halt`=0, and both pulses are 0. Release of `rst_n` takes effect after two rising edges.
- R11: Interrupt inputs going low while the block is not driving produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wai_exec | input | 1 | One-cycle strobe: wait instruction executed |
| stp_exec | input | 1 | One-cycle strobe: stop instruction executed (no effect) |
| abort_n | input | 1 | Abort request, active low |
| nmi_n | input | 1 | Non-maskable interrupt, active low |
| irq_n | input | 1 | Maskable interrupt request, active low |
| irq_mask | input | 1 | Core interrupt disable flag, 1 = masked |
| pad_level | input | 1 | Resolved level of the shared ready line |
| rdy_drive_low | output | 1 | Open-drain enable: 1 pulls the line low |
| rdy_pullup_en | output | 1 | Pull-up enable for the line |
| core_halt | output | 1 | Freeze request to the core |
| take_vector | output | 1 | One-cycle pulse: service the interrupt through its vector |
| resume_no_vector | output | 1 | One-cycle pulse: continue with the next instruction |

## Verification
A wait state that is stuck set shows up as `rdy_drive_low` staying high after a wake edge, visible one cycle later. A lost wait state shows up as no drive the cycle after `wai_exec`. A wrong wake decode surfaces as the wrong pulse, or a missing pulse, in the single cycle after the wake edge. A settle counter with the wrong length moves the forced-high release by whole cycles. A synchroniser of the wrong depth or a halt register on the wrong edge shifts `core_halt` by a half or whole cycle, so the bench samples halt both just before and just after the expected falling edge.

// File: rtl/wrc_pkg.sv
`timescale 1ns/1ps
package wrc_pkg;

  // Controller mode: free running, or parked low after a wait instruction
  typedef enum logic [0:0] {
    WRC_RUN  = 1'b0,
    WRC_WAIT = 1'b1
  } wrc_state_e;

  // Wake requests, active high after inversion at the top level
  typedef struct packed {
    logic abort;
    logic nmi;
    logic irq;
  } wrc_wake_t;

endpackage

// File: rtl/wrc_sync.sv
`timescale 1ns/1ps
module wrc_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = d;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{RESET_VAL}};
    end else begin
      chain_q <= chain_d;
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/wrc_wait_fsm.sv
`timescale 1ns/1ps
module wrc_wait_fsm
  import wrc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wai_exec,
  input  wrc_wake_t wake,
  input  logic      irq_mask,
  input  logic      pad_sync,
  output logic      drive_low,
  output logic      take_vec,
  output logic      skip_vec
);

  // Cycles the pad needs to reflect our own pull-down through the synchroniser
  localparam int SETTLE = SYNC_STAGES + 1;
  localparam int CNT_W  = $clog2(SETTLE + 1);
  localparam logic [CNT_W-1:0] SETTLE_C = CNT_W'(SETTLE);
  localparam logic [CNT_W-1:0] ONE_C    = CNT_W'(1);

  wrc_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             take_q, take_d;
  logic             skip_q, skip_d;
  logic             any_wake;
  logic             vec_wake;
  logic             settled;

  always_comb begin
    any_wake = wake.abort | wake.nmi | wake.irq;
    vec_wake = wake.abort | wake.nmi | (wake.irq & ~irq_mask);
    settled  = (cnt_q == SETTLE_C);
  end

  // Next-state process
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    take_d  = 1'b0;
    skip_d  = 1'b0;
    unique case (state_q)
      WRC_RUN: begin
        if (wai_exec) begin
          state_d = WRC_WAIT;
          cnt_d   = '0;
        end
      end
      WRC_WAIT: begin
        if (any_wake) begin
          state_d = WRC_RUN;
          take_d  = vec_wake;
          skip_d  = ~vec_wake;
        end else if (settled && pad_sync) begin
          // line held high by another agent: the wait is defeated
          state_d = WRC_RUN;
        end else if (!settled) begin
          cnt_d = cnt_q + ONE_C;
        end
      end
      default: state_d = WRC_RUN;
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WRC_RUN;
      cnt_q   <= '0;
      take_q  <= 1'b0;
      skip_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      take_q  <= take_d;
      skip_q  <= skip_d;
    end
  end

  assign drive_low = (state_q == WRC_WAIT);
  assign take_vec  = take_q;
  assign skip_vec  = skip_q;

endmodule

// File: rtl/wrc_halt_gen.sv
`timescale 1ns/1ps
module wrc_halt_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic pad_sync,
  output logic halt
);

  logic halt_q;
  logic halt_d;

  always_comb halt_d = ~pad_sync;

  // Halt is applied and released only on the falling clock edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q <= 1'b0;
    end else begin
      halt_q <= halt_d;
    end
  end

  assign halt = halt_q;

endmodule

// File: rtl/wrc_ready_ctrl.sv
`timescale 1ns/1ps
module wrc_ready_ctrl
  import wrc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wai_exec,
  input  logic stp_exec,
  input  logic abort_n,
  input  logic nmi_n,
  input  logic irq_n,
  input  logic irq_mask,
  input  logic pad_level,
  output logic rdy_drive_low,
  output logic rdy_pullup_en,
  output logic core_halt,
  output logic take_vector,
  output logic resume_no_vector
);

  logic      rst_sync_n;
  logic      pad_sync;
  logic      drive_low;
  wrc_wake_t wake;
  logic      unused_stp;

  // The stop strobe is accepted but deliberately has no effect on the line
  assign unused_stp = stp_exec;

  wrc_sync #(
    .STAGES    (RST_STAGES),
    .RESET_VAL (1'b0)
  ) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_sync_n)
  );

  wrc_sync #(
    .STAGES    (SYNC_STAGES),
    .RESET_VAL (1'b1)
  ) u_pad_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (pad_level),
    .q     (pad_sync)
  );

  always_comb begin
    wake.abort = ~abort_n;
    wake.nmi   = ~nmi_n;
    wake.irq   = ~irq_n;
  end

  wrc_wait_fsm #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wai_exec  (wai_exec),
    .wake      (wake),
    .irq_mask  (irq_mask),
    .pad_sync  (pad_sync),
    .drive_low (drive_low),
    .take_vec  (take_vector),
    .skip_vec  (resume_no_vector)
  );

  wrc_halt_gen u_halt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .pad_sync (pad_sync),
    .halt     (core_halt)
  );

  // Open-drain drive; the pull-up is off while pulling low
  assign rdy_drive_low = drive_low & rst_n;
  assign rdy_pullup_en = ~rdy_drive_low;

endmodule

// File: rtl/wrc_ready_ctrl_chk.sv
`timescale 1ns/1ps
module wrc_ready_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic wai_exec,
  input logic stp_exec,
  input logic abort_n,
  input logic nmi_n,
  input logic irq_n,
  input logic irq_mask,
  input logic drive_low,
  input logic take_vector,
  input logic resume_no_vector
);

  p_wai_drives_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!drive_low && wai_exec) |=> drive_low);

  p_wake_releases_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_low && (!abort_n || !nmi_n || !irq_n)) |=> !drive_low);

  p_vector_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_low && (!abort_n || !nmi_n || (!irq_n && !irq_mask)))
      |=> (take_vector && !resume_no_vector));

  p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take_vector |=> !take_vector);

  p_pulse_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(take_vector && resume_no_vector));

  p_masked_resume_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_low && abort_n && nmi_n && !irq_n && irq_mask)
      |=> (resume_no_vector && !take_vector));

  p_stp_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!drive_low && !wai_exec && stp_exec) |=> !drive_low);

  p_idle_no_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_low |=> (!take_vector && !resume_no_vector));

endmodule

bind wrc_ready_ctrl wrc_ready_ctrl_chk u_chk (
  .clk              (clk),
  .rst_n            (rst_sync_n),
  .wai_exec         (wai_exec),
  .stp_exec         (stp_exec),
  .abort_n          (abort_n),
  .nmi_n            (nmi_n),
  .irq_n            (irq_n),
  .irq_mask         (irq_mask),
  .drive_low        (rdy_drive_low),
  .take_vector      (take_vector),
  .resume_no_vector (resume_no_vector)
);

// File: tb/wrc_ready_ctrl_bench.sv
`timescale 1ns/1ps
module wrc_ready_ctrl_bench;

  localparam int SYNC = 2;
  localparam int NV   = 27;

  logic clk = 1'b0;
  logic rst_n, wai_exec, stp_exec, abort_n, nmi_n, irq_n, irq_mask;
  logic ext_low, force_hi;
  logic pad_level;
  logic rdy_drive_low, rdy_pullup_en, core_halt, take_vector, resume_no_vector;
  int   checks = 0;
  int   failures = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  // Resolved wire: another agent may force it high or pull it low
  assign pad_level = force_hi ? 1'b1 : !(rdy_drive_low || ext_low);

  wrc_ready_ctrl #(.SYNC_STAGES(SYNC)) u_wrc_ready_ctrl (
    .clk              (clk),
    .rst_n            (rst_n),
    .wai_exec         (wai_exec),
    .stp_exec         (stp_exec),
    .abort_n          (abort_n),
    .nmi_n            (nmi_n),
    .irq_n            (irq_n),
    .irq_mask         (irq_mask),
    .pad_level        (pad_level),
    .rdy_drive_low    (rdy_drive_low),
    .rdy_pullup_en    (rdy_pullup_en),
    .core_halt        (core_halt),
    .take_vector      (take_vector),
    .resume_no_vector (resume_no_vector)
  );

  // {wai, stp, abort_n, nmi_n, irq_n, mask, ext_low, force_hi, exp drive, exp take, exp skip}
  localparam logic [10:0] VEC [NV] = '{
    11'b0011_1000_000, // 0 idle
    11'b0111_1000_000, // 1 stp idle R8
    11'b1011_1000_100, // 2 wai R3
    11'b0011_1000_100, // 3 hold
    11'b0111_1000_100, // 4 stp while waiting R8
    11'b0011_0000_010, // 5 irq unmasked R4 R5
    11'b0011_1000_000, // 6
    11'b1011_1000_100, // 7 wai
    11'b0011_1000_100, // 8
    11'b0011_0100_001, // 9 irq masked R6
    11'b0011_1100_000, // 10
    11'b1011_1000_100, // 11 wai
    11'b0010_1000_010, // 12 nmi R5
    11'b0011_1000_000, // 13
    11'b1011_1000_100, // 14 wai
    11'b0001_1000_010, // 15 abort R5
    11'b0011_1000_000, // 16
    11'b1011_1001_100, // 17 wai, line forced high R7
    11'b0011_1001_100, // 18
    11'b0011_1001_100, // 19
    11'b0011_1001_100, // 20
    11'b0011_1001_000, // 21 defeated R7
    11'b0011_1000_000, // 22
    11'b1011_0100_100, // 23 wai with masked irq already low
    11'b0011_0100_001, // 24 R6
    11'b0011_1000_000, // 25
    11'b0011_0000_000  // 26 irq while idle R11
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic set_in(input logic [7:0] s);
    {wai_exec, stp_exec, abort_n, nmi_n, irq_n, irq_mask, ext_low, force_hi} = s;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    set_in(8'b0011_1000);
    repeat (3) tick();
    chk("R10 drive in reset", rdy_drive_low, 1'b0);
    chk("R10 pullup in reset", rdy_pullup_en, 1'b1);
    chk("R10 halt in reset", core_halt, 1'b0);
    chk("R10 take in reset", take_vector, 1'b0);
    chk("R10 skip in reset", resume_no_vector, 1'b0);
    rst_n = 1'b1;
    repeat (4) tick();

    // table walk
    for (int i = 0; i < NV; i++) begin
      set_in(VEC[i][10:3]);
      tick();
      chk($sformatf("R3/R4/R7 drive row %0d", i), rdy_drive_low, VEC[i][2]);
      chk($sformatf("R5 take row %0d", i), take_vector, VEC[i][1]);
      chk($sformatf("R6/R11 skip row %0d", i), resume_no_vector, VEC[i][0]);
      chk($sformatf("R9 pullup row %0d", i), rdy_pullup_en, !VEC[i][2]);
    end
    set_in(8'b0011_1000);
    repeat (4) tick();

    // R1: external low halts at the falling edge after SYNC rising edges
    ext_low = 1'b1;
    repeat (SYNC) tick();
    chk("R1 halt before falling edge", core_halt, 1'b0);
    #2;
    chk("R1 halt after falling edge", core_halt, 1'b1);
    tick();
    // R2: release only at the falling edge
    ext_low = 1'b0;
    repeat (SYNC) tick();
    chk("R2 halt held until falling edge", core_halt, 1'b1);
    #2;
    chk("R2 halt released at falling edge", core_halt, 1'b0);
    tick();

    // R1: the block's own drive also halts the core
    wai_exec = 1'b1;
    tick();
    wai_exec = 1'b0;
    repeat (SYNC) tick();
    #2;
    chk("R1 self-driven halt", core_halt, 1'b1);
    tick();

    // R10: asynchronous reset while waiting
    chk("R3 drive before reset", rdy_drive_low, 1'b1);
    rst_n = 1'b0;
    #0.5;
    chk("R10 drive drops without clock", rdy_drive_low, 1'b0);
    chk("R10 pullup back on", rdy_pullup_en, 1'b1);
    tick();
    chk("R10 halt cleared", core_halt, 1'b0);
    rst_n = 1'b1;
    repeat (6) tick();
    chk("R10 stays idle after reset", rdy_drive_low, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule